// File: doc/BRIEF.md
# Bit-Reversed FFT Write Address Generator

This block computes the effective address and the updated pointer for one indirect data access per request. For writes, it can step a pointer through a power-of-two buffer in bit-reversed index order. That is the reordering a radix-2 FFT needs. The modifier (the pivot) is added with its carry running from the high bits toward the low bits. The pointer itself keeps its normal bit order.

Reversed stepping is qualified by several conditions:

- the enable input is set;
- the selected pointer register is not the stack pointer;
- the mode is pre-increment or post-increment;
- the access is a word write.

In every other case the block produces the normal indirect address. A modulo request is passed through on reads. On writes, bit-reversal overrides the modulo request.

A request is sampled on a rising clock edge. The results are registered and appear one cycle later. For an FFT over a buffer of 2^N bytes, the buffer must start where the low N address bits are zero. The pivot is set to half the buffer length in words. It is scaled to bytes internally.

Top module: `bitrev_agu`

## Requirements
- R1: While rst_n is low, out_valid, ea, ptr_next, rev_applied and mod_active are all zero.
- R2: A request sampled with req high at a rising edge appears on the outputs after that edge, with out_valid high for one cycle. Without req, out_valid is low and the other outputs hold their values.
- R3: rev_applied is 1 only when all of these hold: rev_en=1, ptr_sel is not 15, mode is 2 or 4, byte_op=0 and is_write=1.
- R4: Without bit-reversal, the step is 1 for byte_op=1 and 2 otherwise. Mode 0 gives ea=ptr_next=ptr_in. Mode 1 (post-decrement) gives ea=ptr_in and ptr_next=ptr_in-step. Mode 2 (post-increment) gives ea=ptr_in and ptr_next=ptr_in+step. Mode 3 (pre-decrement) gives ea=ptr_next=ptr_in-step. Mode 4 (pre-increment) gives ea=ptr_next=ptr_in+step. Modes 5 to 7 behave as mode 0.
- R5: With bit-reversal, the increment step is ignored. The new pointer is ptr_in plus pivot*2, added with the carry moving from bit AW-1 toward bit 1. Any carry out of bit 1 is discarded.
- R6: With bit-reversal, mode 2 gives ea=ptr_in and mode 4 gives ea=ptr_next.
- R7: With bit-reversal, bit 0 of both ea and ptr_next is zero, whatever bit 0 of ptr_in is.
- R8: With bit-reversal, pointer bits above the highest set bit of pivot*2 pass through unchanged.
- R9: Consider a buffer of 2^N bytes that starts at an address with its low N bits zero, with pivot = 2^(N-2) (half the buffer in words). Repeated post-increment steps then visit the word addresses start + 2*bitrev(k) for k = 0 .. 2^(N-1)-1, and the next step returns to start.
- R10: mod_active equals mod_en except when bit-reversal is applied, in which case it is 0. On reads (is_write=0), mod_active always follows mod_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, sampled each rising edge |
| is_write | input | 1 | 1 for a data write, 0 for a read |
| ptr_in | input | AW | Current pointer value (byte address) |
| pivot | input | AW-1 | Reversal modifier in words |
| rev_en | input | 1 | Bit-reversal enable |
| ptr_sel | input | 4 | Index of the pointer register in use (15 = stack pointer) |
| mode | input | 3 | Addressing mode, encoded as in R4 |
| byte_op | input | 1 | 1 for a byte access, 0 for a word access |
| mod_en | input | 1 | Modulo addressing request |
| out_valid | output | 1 | Results updated this cycle |
| ea | output | AW | Effective address |
| ptr_next | output | AW | Updated pointer value |
| rev_applied | output | 1 | Bit-reversal was used for this access |
| mod_active | output | 1 | Modulo correction is to be applied |

## Verification
The only internal state is the result register and the carry chain of the reversed adder. Both are visible at the ports one cycle after each request. A wrong carry direction, or a carry that leaks into bit 0 or into upper bits, shows up as a wrong ptr_next on the first access whose reversed sum carries. A mis-qualified enable shows up the same cycle as a wrong rev_applied and a normal-order address. The buffer sweep feeds ptr_next back as the next pointer, so a single bad step corrupts every later address in that sweep and the return to the start address.

// File: rtl/bitrev_agu.sv
module bitrev_agu #(
  parameter int AW     = 16,
  parameter int SP_SEL = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          is_write,
  input  logic [AW-1:0] ptr_in,
  input  logic [AW-2:0] pivot,
  input  logic          rev_en,
  input  logic [3:0]    ptr_sel,
  input  logic [2:0]    mode,
  input  logic          byte_op,
  input  logic          mod_en,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] ptr_next,
  output logic          rev_applied,
  output logic          mod_active
);
  localparam logic [2:0] M_POSTDEC = 3'd1;
  localparam logic [2:0] M_POSTINC = 3'd2;
  localparam logic [2:0] M_PREDEC  = 3'd3;
  localparam logic [2:0] M_PREINC  = 3'd4;

  logic          use_rev;
  logic [AW-1:0] step, rev_sum, nrm_ptr, nrm_ea, c_ea, c_ptr;
  logic [AW-1:0] mod_bytes;

  assign mod_bytes = {pivot, 1'b0};
  assign step      = byte_op ? AW'(1) : AW'(2);

  assign use_rev = rev_en && (ptr_sel != 4'(SP_SEL)) && is_write && !byte_op &&
                   (mode == M_POSTINC || mode == M_PREINC);

  always_comb begin
    logic cy;
    cy = 1'b0;
    rev_sum = '0;
    for (int i = AW-1; i >= 1; i--) begin
      rev_sum[i] = ptr_in[i] ^ mod_bytes[i] ^ cy;
      cy = (ptr_in[i] & mod_bytes[i]) | (cy & (ptr_in[i] ^ mod_bytes[i]));
    end
  end

  always_comb begin
    nrm_ea  = ptr_in;
    nrm_ptr = ptr_in;
    unique case (mode)
      M_POSTDEC: nrm_ptr = ptr_in - step;
      M_POSTINC: nrm_ptr = ptr_in + step;
      M_PREDEC: begin nrm_ptr = ptr_in - step; nrm_ea = nrm_ptr; end
      M_PREINC: begin nrm_ptr = ptr_in + step; nrm_ea = nrm_ptr; end
      default: ;
    endcase
  end

  assign c_ptr = use_rev ? rev_sum : nrm_ptr;
  assign c_ea  = !use_rev ? nrm_ea :
                 (mode == M_PREINC) ? rev_sum : {ptr_in[AW-1:1], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      ea          <= '0;
      ptr_next    <= '0;
      rev_applied <= 1'b0;
      mod_active  <= 1'b0;
    end else begin
      out_valid <= req;
      if (req) begin
        ea          <= c_ea;
        ptr_next    <= c_ptr;
        rev_applied <= use_rev;
        mod_active  <= mod_en && !use_rev;
      end
    end
  end
endmodule

module bitrev_agu_chk #(
  parameter int AW     = 16,
  parameter int SP_SEL = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          is_write,
  input logic [AW-1:0] ptr_in,
  input logic          rev_en,
  input logic [3:0]    ptr_sel,
  input logic [2:0]    mode,
  input logic          byte_op,
  input logic          mod_en,
  input logic          out_valid,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] ptr_next,
  input logic          rev_applied,
  input logic          mod_active
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!out_valid && $stable(ea) && $stable(ptr_next)));

  assert_no_rev_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ptr_sel == 4'(SP_SEL)) |=> !rev_applied);

  assert_no_rev_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (byte_op || !is_write || !rev_en)) |=> !rev_applied);

  assert_postinc_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !rev_en && !byte_op && mode == 3'd2) |=>
      (ptr_next == $past(ptr_in) + AW'(2) && ea == $past(ptr_in)));

  assert_lsb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rev_applied |-> (ea[0] == 1'b0 && ptr_next[0] == 1'b0));

  assert_mod_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rev_applied |-> !mod_active);

  assert_read_mod_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_write) |=> (mod_active == $past(mod_en)));
endmodule

bind bitrev_agu bitrev_agu_chk #(.AW(AW), .SP_SEL(SP_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .is_write(is_write), .ptr_in(ptr_in),
  .rev_en(rev_en), .ptr_sel(ptr_sel), .mode(mode), .byte_op(byte_op),
  .mod_en(mod_en), .out_valid(out_valid), .ea(ea), .ptr_next(ptr_next),
  .rev_applied(rev_applied), .mod_active(mod_active)
);

// File: tb/tb_bitrev_agu.sv
module tb_bitrev_agu;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, is_write = 1'b0, rev_en = 1'b0, byte_op = 1'b0, mod_en = 1'b0;
  logic [AW-1:0] ptr_in = '0;
  logic [AW-2:0] pivot = '0;
  logic [3:0]    ptr_sel = '0;
  logic [2:0]    mode = '0;
  logic          out_valid, rev_applied, mod_active;
  logic [AW-1:0] ea, ptr_next;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitrev_agu #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .is_write(is_write), .ptr_in(ptr_in),
    .pivot(pivot), .rev_en(rev_en), .ptr_sel(ptr_sel), .mode(mode),
    .byte_op(byte_op), .mod_en(mod_en), .out_valid(out_valid), .ea(ea),
    .ptr_next(ptr_next), .rev_applied(rev_applied), .mod_active(mod_active)
  );

  typedef struct packed {
    logic [15:0] ptr;
    logic [14:0] piv;
    logic        en;
    logic [3:0]  sel;
    logic [2:0]  md;
    logic        byt;
    logic        wr;
    logic        men;
    logic [15:0] x_ea;
    logic [15:0] x_ptr;
    logic        x_rev;
    logic        x_mod;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{16'h0100, 15'd4,  1, 4'd2,  3'd2, 0, 1, 0, 16'h0100, 16'h0108, 1, 0}, // R5 R6 post
    '{16'h0108, 15'd4,  1, 4'd2,  3'd4, 0, 1, 0, 16'h0104, 16'h0104, 1, 0}, // R5 R6 pre
    '{16'h010E, 15'd4,  1, 4'd2,  3'd2, 0, 1, 0, 16'h010E, 16'h0100, 1, 0}, // R5 carry drops
    '{16'h0100, 15'd4,  1, 4'd2,  3'd2, 1, 1, 0, 16'h0100, 16'h0101, 0, 0}, // R3 byte
    '{16'h0200, 15'd4,  1, 4'd15, 3'd2, 0, 1, 0, 16'h0200, 16'h0202, 0, 0}, // R3 stack ptr
    '{16'h0300, 15'd4,  0, 4'd2,  3'd4, 0, 1, 0, 16'h0302, 16'h0302, 0, 0}, // R3 disabled, R4
    '{16'h0400, 15'd4,  1, 4'd2,  3'd0, 0, 1, 0, 16'h0400, 16'h0400, 0, 0}, // R3 mode 0
    '{16'h0500, 15'd4,  1, 4'd2,  3'd2, 0, 0, 1, 16'h0500, 16'h0502, 0, 1}, // R3 R10 read
    '{16'h0600, 15'd16, 1, 4'd3,  3'd2, 0, 1, 1, 16'h0600, 16'h0620, 1, 0}, // R10 priority
    '{16'h0700, 15'd4,  0, 4'd3,  3'd1, 0, 1, 1, 16'h0700, 16'h06FE, 0, 1}, // R4 R10 postdec
    '{16'h0801, 15'd4,  0, 4'd3,  3'd3, 1, 1, 0, 16'h0800, 16'h0800, 0, 0}, // R4 predec byte
    '{16'h0103, 15'd4,  1, 4'd1,  3'd4, 0, 1, 0, 16'h010A, 16'h010A, 1, 0}, // R7 odd pointer
    '{16'hF006, 15'd4,  1, 4'd1,  3'd2, 0, 1, 0, 16'hF006, 16'hF00E, 1, 0}, // R8 upper bits
    '{16'h8000, 15'h4000, 1, 4'd0, 3'd2, 0, 1, 0, 16'h8000, 16'h4000, 1, 0}  // R5 top pivot bit
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] p, input logic [14:0] pv, input logic en,
                       input logic [3:0] sl, input logic [2:0] md, input logic b,
                       input logic w, input logic me);
    @(negedge clk);
    ptr_in = p; pivot = pv; rev_en = en; ptr_sel = sl; mode = md;
    byte_op = b; is_write = w; mod_en = me; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [2:0] brev3(input int k);
    logic [2:0] v;
    v = 3'(k);
    return {v[0], v[1], v[2]};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 valid", 32'(out_valid), 0);
    check("R1 ea", 32'(ea), 0);
    check("R1 ptr", 32'(ptr_next), 0);
    check("R1 rev/mod", {30'd0, rev_applied, mod_active}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].ptr, VEC[i].piv, VEC[i].en, VEC[i].sel, VEC[i].md,
            VEC[i].byt, VEC[i].wr, VEC[i].men);
      check($sformatf("R2 valid v%0d", i), 32'(out_valid), 1);
      check($sformatf("R4/R5 ea v%0d", i), 32'(ea), 32'(VEC[i].x_ea));
      check($sformatf("R4/R5 ptr v%0d", i), 32'(ptr_next), 32'(VEC[i].x_ptr));
      check($sformatf("R3 rev v%0d", i), 32'(rev_applied), 32'(VEC[i].x_rev));
      check($sformatf("R10 mod v%0d", i), 32'(mod_active), 32'(VEC[i].x_mod));
    end

    // R2: without req, outputs hold while inputs change
    ptr_in = 16'h1234; mode = 3'd4; rev_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 hold valid", 32'(out_valid), 0);
    check("R2 hold ea", 32'(ea), 32'(16'h8000));
    check("R2 hold ptr", 32'(ptr_next), 32'(16'h4000));

    // R4: modes 5..7 behave as mode 0
    issue(16'h0A00, 15'd4, 1, 4'd2, 3'd6, 0, 1, 0);
    check("R4 mode6 ea", 32'(ea), 32'(16'h0A00));
    check("R4 mode6 ptr", 32'(ptr_next), 32'(16'h0A00));

    // R9: 16-byte buffer at 0x0100, pivot 4 words, pointer fed back
    begin
      logic [15:0] p;
      p = 16'h0100;
      for (int k = 0; k <= 8; k++) begin
        issue(p, 15'd4, 1, 4'd5, 3'd2, 0, 1, 0);
        check($sformatf("R9 step %0d", k), 32'(ea),
              32'(16'h0100 + 16'(2 * int'(brev3(k % 8)))));
        p = ptr_next;
      end
    end

    // R1: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid ea", 32'(ea), 0);
    check("R1 mid valid", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule